// File: doc/BRIEF.md
# Mode-Dependent Multiplexed I/O Port

An eight-pin general-purpose I/O port that sits on a simple CPU register bus. Software sets each pin's direction and output level through a direction register and a data register. A fixed per-pin multiplexer hands some pins to timer, interrupt, conversion-trigger, clock, strobe and bus-arbitration functions. Which functions apply depends on whether the device runs in single-chip or expanded mode.

The two lowest pins can only be inputs as port pins. Their drivers always belong to the clock output (pin 1) and the strobe output (pin 0). When an alternate output is active, the peripheral value drives the pad and the pad driver is switched on, whatever the direction register holds. Routed peripheral inputs always sample the pad. The bus-control inputs are held inactive in single-chip mode. A system control register at its own address is decoded and held only.

Writes take effect on the rising clock edge. Reads are combinational from the address and the read strobe.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, direction bits 7..2 are 0, data latch bits 7..2 are 0, and the system control register reads 8'h87.
- R2: A read of the direction register address (16'hFE80) returns 8'hFF. A write there sets the direction of pins 7..2 from wdata[7:2], where 1 means output. wdata[1:0] have no effect on pins 1 and 0.
- R3: Pins 6..3, and pins 7 and 2 when their alternate output is not active, have pad_oe equal to their direction bit and pad_out equal to their data latch bit. The data latch is written at 16'hFE82.
- R4: A read of the data register address returns the latch for pins 7..2 whose direction bit is 1. It returns pad_in for pins whose direction bit is 0, and for pins 1 and 0 always.
- R5: While tmr_en is 1, pad_oe[7] is 1 and pad_out[7] equals tmr_val.
- R6: In expanded mode (expanded=1), pad_oe[2] is 1 and pad_out[2] equals back_val. In single-chip mode, pin 2 is plain I/O.
- R7: pad_oe[1] equals eclk_en and pad_oe[0] equals strb_en, with pad_out[1]=eclk_val and pad_out[0]=strb_val when enabled.
- R8: irq1 and conv_trig equal pad_in[6], and irq0 equals pad_in[5], whatever the direction setting.
- R9: wait_req equals pad_in[4] and bus_req equals pad_in[3] in expanded mode. Both are 0 in single-chip mode.
- R10: The system control register at 16'hFEFC holds any written byte and reads it back.
- R11: A read of any other address returns 8'h00. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| expanded | input | 1 | 1 = expanded mode, 0 = single-chip mode |
| addr | input | 16 | Register bus address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| tmr_en | input | 1 | Timer output owns pin 7 |
| tmr_val | input | 1 | Timer output level |
| back_val | input | 1 | Bus acknowledge level for pin 2 |
| eclk_en | input | 1 | Clock output drives pin 1 |
| eclk_val | input | 1 | Clock output level |
| strb_en | input | 1 | Strobe output drives pin 0 |
| strb_val | input | 1 | Strobe output level |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad driver enables |
| pad_out | output | 8 | Pad output levels |
| irq1 | output | 1 | Interrupt request 1 from pin 6 |
| irq0 | output | 1 | Interrupt request 0 from pin 5 |
| conv_trig | output | 1 | Conversion trigger from pin 6 |
| wait_req | output | 1 | Wait input from pin 4 |
| bus_req | output | 1 | Bus request from pin 3 |

## Verification
The hardest case to reach is a pin whose ownership changes under it. The data latch holds one value while the pin is given to a peripheral, and software expects that value back on the pad once the peripheral lets go. A read of the data register must also pick pad or latch per bit as the direction bits change. Random sequences of register writes are interleaved with random toggling of the mode and the peripheral enables, so ownership changes land on every kind of direction and latch state. Directed steps cover reset, the write-only direction read and unmapped addresses.

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int          AW       = 16,
  parameter logic [15:0] DDR_ADDR = 16'hFE80,
  parameter logic [15:0] DR_ADDR  = 16'hFE82,
  parameter logic [15:0] SYS_ADDR = 16'hFEFC,
  parameter logic [7:0]  SYS_RST  = 8'h87
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expanded,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          tmr_en,
  input  logic          tmr_val,
  input  logic          back_val,
  input  logic          eclk_en,
  input  logic          eclk_val,
  input  logic          strb_en,
  input  logic          strb_val,
  input  logic [7:0]    pad_in,
  output logic [7:0]    pad_oe,
  output logic [7:0]    pad_out,
  output logic          irq1,
  output logic          irq0,
  output logic          conv_trig,
  output logic          wait_req,
  output logic          bus_req
);

  logic [7:2] dir_q, lat_q;
  logic [7:0] sys_q;

  wire hit_dir = (addr == AW'(DDR_ADDR));
  wire hit_dat = (addr == AW'(DR_ADDR));
  wire hit_sys = (addr == AW'(SYS_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
      sys_q <= SYS_RST;
    end else if (wr_en) begin
      if (hit_dir) dir_q <= wdata[7:2];
      if (hit_dat) lat_q <= wdata[7:2];
      if (hit_sys) sys_q <= wdata;
    end
  end

  always_comb begin
    pad_oe  = {dir_q, 2'b00};
    pad_out = {lat_q, 2'b00};
    if (tmr_en) begin
      pad_oe[7]  = 1'b1;
      pad_out[7] = tmr_val;
    end
    if (expanded) begin
      pad_oe[2]  = 1'b1;
      pad_out[2] = back_val;
    end
    pad_oe[1]  = eclk_en;
    pad_out[1] = eclk_val;
    pad_oe[0]  = strb_en;
    pad_out[0] = strb_val;
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (hit_dir)      rdata = 8'hFF;
      else if (hit_dat) rdata = {(dir_q & lat_q) | (~dir_q & pad_in[7:2]), pad_in[1:0]};
      else if (hit_sys) rdata = sys_q;
    end
  end

  assign irq1      = pad_in[6];
  assign conv_trig = pad_in[6];
  assign irq0      = pad_in[5];
  assign wait_req  = expanded & pad_in[4];
  assign bus_req   = expanded & pad_in[3];

endmodule

module gpio_mux_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        expanded,
  input logic [15:0] addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        tmr_en,
  input logic        tmr_val,
  input logic        back_val,
  input logic        eclk_en,
  input logic        strb_en,
  input logic [7:0]  pad_in,
  input logic [7:0]  pad_oe,
  input logic [7:0]  pad_out,
  input logic        irq1,
  input logic        irq0,
  input logic        wait_req,
  input logic        bus_req
);
  AST_DIR_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 16'hFE80) |-> rdata == 8'hFF); // R2
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 16'hFE80) |=> pad_oe[6:3] == $past(wdata[6:3])); // R3
  AST_TMR_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_en |-> (pad_oe[7] && pad_out[7] == tmr_val)); // R5
  AST_BACK_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    expanded |-> (pad_oe[2] && pad_out[2] == back_val)); // R6
  AST_LOW_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[1:0] == {eclk_en, strb_en}); // R7
  AST_IRQ_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 == pad_in[6] && irq0 == pad_in[5]); // R8
  AST_BUS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !expanded |-> (!wait_req && !bus_req)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != 16'hFE80 && addr != 16'hFE82 && addr != 16'hFEFC) |-> rdata == 8'h00); // R11
endmodule

bind gpio_mux_port gpio_mux_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .expanded(expanded), .addr(addr), .wr_en(wr_en),
  .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .tmr_en(tmr_en), .tmr_val(tmr_val),
  .back_val(back_val), .eclk_en(eclk_en), .strb_en(strb_en), .pad_in(pad_in),
  .pad_oe(pad_oe), .pad_out(pad_out), .irq1(irq1), .irq0(irq0),
  .wait_req(wait_req), .bus_req(bus_req)
);

// File: tb/test_gpio_mux_port.sv
module test_gpio_mux_port;
  logic clk = 0, rst_n = 0;
  logic expanded = 0, wr_en = 0, rd_en = 0;
  logic [15:0] addr = 16'h0;
  logic [7:0] wdata = 0, pad_in = 0;
  logic tmr_en = 0, tmr_val = 0, back_val = 0, eclk_en = 0, eclk_val = 0, strb_en = 0, strb_val = 0;
  logic [7:0] rdata, pad_oe, pad_out;
  logic irq1, irq0, conv_trig, wait_req, bus_req;

  int checks = 0, fails = 0;
  logic [7:2] dir_m, lat_m;
  logic [7:0] sys_m;

  always #5 clk = ~clk;

  gpio_mux_port i_gpio_mux_port (
    .clk(clk), .rst_n(rst_n), .expanded(expanded), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .tmr_en(tmr_en), .tmr_val(tmr_val),
    .back_val(back_val), .eclk_en(eclk_en), .eclk_val(eclk_val), .strb_en(strb_en),
    .strb_val(strb_val), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .irq1(irq1), .irq0(irq0), .conv_trig(conv_trig), .wait_req(wait_req), .bus_req(bus_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] e_oe();
    logic [7:0] v = {dir_m, 2'b00};
    if (tmr_en) v[7] = 1'b1;
    if (expanded) v[2] = 1'b1;
    v[1] = eclk_en;
    v[0] = strb_en;
    return v;
  endfunction

  function automatic logic [7:0] e_out();
    logic [7:0] v = {lat_m, 2'b00};
    if (tmr_en) v[7] = tmr_val;
    if (expanded) v[2] = back_val;
    v[1] = eclk_val;
    v[0] = strb_val;
    return v;
  endfunction

  function automatic logic [7:0] e_rd();
    if (!rd_en) return 8'h00;
    case (addr)
      16'hFE80: return 8'hFF;
      16'hFE82: return {(dir_m & lat_m) | (~dir_m & pad_in[7:2]), pad_in[1:0]};
      16'hFEFC: return sys_m;
      default:  return 8'h00;
    endcase
  endfunction

  task automatic check_all();
    logic [7:0] eo = e_oe();
    logic [7:0] ev = e_out();
    check("R5 pin7 oe", {7'd0, pad_oe[7]}, {7'd0, eo[7]});
    check("R3 pins6-3 oe", {4'd0, pad_oe[6:3]}, {4'd0, eo[6:3]});
    check("R6 pin2 oe", {7'd0, pad_oe[2]}, {7'd0, eo[2]});
    check("R7 pins1-0 oe", {6'd0, pad_oe[1:0]}, {6'd0, eo[1:0]});
    check("R3 R5 R6 R7 out", pad_out & eo, ev & eo);
    check("R8 routed", {5'd0, irq1, conv_trig, irq0}, {5'd0, pad_in[6], pad_in[6], pad_in[5]});
    check("R9 bus ctl", {6'd0, wait_req, bus_req}, {6'd0, expanded & pad_in[4], expanded & pad_in[3]});
    check("R4 R10 R11 rdata", rdata, e_rd());
  endtask

  task automatic bus(input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = ~w; addr = a; wdata = d;
    #1 check_all();
    @(posedge clk);
    if (w) begin
      if (a == 16'hFE80) dir_m = d[7:2];
      if (a == 16'hFE82) lat_m = d[7:2];
      if (a == 16'hFEFC) sys_m = d;
    end
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    dir_m = '0; lat_m = '0; sys_m = 8'h87;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    @(negedge clk); #1;
    check("R1 oe after reset", pad_oe, 8'h00);
    bus(1'b0, 16'hFEFC, 8'h00);
    check("R1 sys reset", rdata, 8'h87);
    bus(1'b1, 16'hFE80, 8'hFC);
    bus(1'b0, 16'hFE82, 8'h00);
    check("R1 latch reset", rdata & 8'hFC, 8'h00);
    // R2 write-only direction, low bits ignored
    bus(1'b1, 16'hFE80, 8'hFF);
    bus(1'b0, 16'hFE80, 8'h00);
    check("R2 dir read", rdata, 8'hFF);
    check("R2 low pins unaffected", {6'd0, pad_oe[1:0]}, 8'h00);
    // R10 system control hold
    bus(1'b1, 16'hFEFC, 8'h5A);
    bus(1'b0, 16'hFEFC, 8'h00);
    check("R10 sys readback", rdata, 8'h5A);
    // R11 unmapped write/read
    bus(1'b1, 16'hFE81, 8'h00);
    bus(1'b1, 16'hFE84, 8'h00);
    bus(1'b0, 16'hFE81, 8'h00);
    check("R11 unmapped read", rdata, 8'h00);
    bus(1'b0, 16'hFE80, 8'h00);
    #1 check("R11 dir kept", pad_oe[7:2], 6'h3F);
    // ownership handoff: latch survives peripheral ownership
    bus(1'b1, 16'hFE82, 8'h84);
    @(negedge clk); tmr_en = 1; tmr_val = 0; expanded = 1; back_val = 0; #1 check_all();
    @(negedge clk); tmr_en = 0; expanded = 0; #1;
    check("R3 pin7 latch after release", {7'd0, pad_out[7]}, 8'h01);
    check("R6 pin2 latch after release", {7'd0, pad_out[2]}, 8'h01);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      int op;
      logic [15:0] a;
      @(negedge clk);
      expanded = $urandom; tmr_en = $urandom; tmr_val = $urandom; back_val = $urandom;
      eclk_en = $urandom; eclk_val = $urandom; strb_en = $urandom; strb_val = $urandom;
      pad_in = $urandom;
      op = $urandom_range(0, 4);
      case (op)
        0: a = 16'hFE80;
        1: a = 16'hFE82;
        2: a = 16'hFEFC;
        3: a = 16'hFE00 | 16'($urandom_range(0, 255));
        default: a = 16'hFE82;
      endcase
      bus($urandom_range(0, 1) == 1, a, 8'($urandom));
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule